// File: doc/BRIEF.md
# Saturating Semaphore Cell

A single storage cell that threads of a multithreaded core share as a counting semaphore. It holds a 16-bit count. A thread reaches the cell through one request port, once per cycle, and picks one of three access views for each request. The two semaphore views treat a store as a V (release) and a load as a P (acquire). A P returns the current count and then lowers it by one. The lowest value the count can take is zero. A V raises the count by one and stops at the all-ones value.

The two semaphore views behave the same except when the count is zero. In the blocking view, a P at zero parks the requester. The requester's bit is set in a per-thread waiting mask, and no response is sent. When a later V finds parked threads, it hands the new count to the lowest-numbered waiter. That waiter's load then completes. The non-blocking view never parks a requester: a P at zero returns zero at once. The tag view reads and writes the cell's tag word. In that word, bit 0 is Empty, bit 1 is Full and bit 2 is the read-only FIFO flag, which is always 0 because this cell is a semaphore. Semaphore traffic never touches the Empty and Full bits.

A three-state controller follows the cell's condition:
- DRAINED: the count is zero and nobody is waiting.
- HOLDING: the count is nonzero.
- BLOCKED: the count is zero and at least one thread is parked.

Its transitions are as follows:
- park: from DRAINED to BLOCKED, on a blocking P at zero.
- fill: from DRAINED to HOLDING, on a V.
- take-last: from HOLDING to DRAINED, on a P when the count is one.
- release-last: from BLOCKED to DRAINED, on a V that wakes the only waiter.
- Every other request leaves the state unchanged.

Top module: `sem_cell`

## Requirements
- R1: A P in either semaphore view (req_view 0 = blocking, 1 = non-blocking, req_write=0) on a nonzero count gives rsp_valid one cycle later, with rsp_tid set to the requester and rsp_data set to the count before the P. The count then reads one less.
- R2: A V (req_write=1 in view 0 or 1) with no waiters raises the count by one. At 16'hFFFF the count stays at 16'hFFFF and never wraps.
- R3: A blocking-view P on a zero count sends no response and sets wait_mask bit [req_tid] in the next cycle. The count stays zero.
- R4: A non-blocking-view P on a zero count responds one cycle later with rsp_data 0. The count and wait_mask are unchanged.
- R5: Semaphore-view loads and stores leave the tag's Empty (bit 0) and Full (bit 1) unchanged.
- R6: A tag-view (req_view 2) read responds with rsp_data = {13'b0, FIFO=0, Full, Empty}. A tag-view write loads Empty from req_wdata[0] and Full from req_wdata[1]. The other written bits, including bit 2, are ignored.
- R7: The data of a V is ignored: every V adds exactly one, whatever the value of req_wdata.
- R8: A V while wait_mask is nonzero clears the lowest set bit of wait_mask. One cycle later it responds to that thread with rsp_data 1, and the count stays zero.
- R9: Reset clears the count, wait_mask, the tag's Empty and Full bits, and rsp_valid.
- R10: A request with req_view 3 has no effect: no response, and the count, wait_mask and tag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_view | input | 2 | 0 blocking P/V, 1 non-blocking P/V, 2 tag, 3 unused |
| req_write | input | 1 | 1 store (V or tag write), 0 load |
| req_tid | input | 2 | Requesting thread number |
| req_wdata | input | 16 | Store data (used only by tag writes) |
| rsp_valid | output | 1 | Load response present |
| rsp_tid | output | 2 | Thread that receives the response |
| rsp_data | output | 16 | Load result |
| cell_count | output | 16 | Current semaphore count |
| wait_mask | output | 4 | Per-thread parked flags |

## Verification
The embedded assertions check the following on every cycle:
- the controller state agrees with the count and with the waiting mask;
- a P on a nonzero count lowers the count by exactly one;
- the count holds at its ceiling;
- parking sets the requester's bit;
- every wake clears exactly one bit;
- the tag does not move unless the tag view writes it.

Only the bench's scenarios can show that the lowest-numbered waiter is the one chosen, that the response carries the right thread and value, that store data is ignored, and that the tag read layout is correct. The bench also shows that the unused view does nothing and that the count really reaches 16'hFFFF after a long run of releases.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        VIEW_PV_BLOCK = 2'd0,
        VIEW_PV_TRY   = 2'd1,
        VIEW_TAG      = 2'd2,
        VIEW_NONE     = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        ST_DRAINED = 2'd0,
        ST_HOLDING = 2'd1,
        ST_BLOCKED = 2'd2
    } cell_st_e;

    localparam int TAG_EMPTY_BIT = 0;
    localparam int TAG_FULL_BIT  = 1;
    localparam int TAG_FIFO_BIT  = 2;
endpackage

// File: rtl/sem_waitq.sv
module sem_waitq #(
    parameter int NT = 4,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park_en,
    input  logic [TW-1:0] park_tid,
    input  logic          release_en,
    output logic [NT-1:0] mask,
    output logic          any,
    output logic          last,
    output logic [TW-1:0] head_tid
);
    logic [NT-1:0] mask_q, mask_n;

    always_comb begin
        head_tid = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (mask_q[i]) head_tid = TW'(i);
        end
    end

    always_comb begin
        mask_n = mask_q;
        if (park_en)    mask_n[park_tid] = 1'b1;
        if (release_en) mask_n[head_tid] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_n;
    end

    assign mask = mask_q;
    assign any  = |mask_q;
    assign last = any && ((mask_q & (mask_q - NT'(1))) == '0);

    // R3
    park_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_en |=> mask_q[$past(park_tid)]);

    // R8
    wake_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_en && !park_en && any) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/sem_tag.sv
module sem_tag #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_bits,
    output logic [CW-1:0] tag
);
    import sem_pkg::*;
    logic empty_q, full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
            full_q  <= 1'b0;
        end else if (wr_en) begin
            empty_q <= wr_bits[0];
            full_q  <= wr_bits[1];
        end
    end

    always_comb begin
        tag = '0;
        tag[TAG_EMPTY_BIT] = empty_q;
        tag[TAG_FULL_BIT]  = full_q;
        tag[TAG_FIFO_BIT]  = 1'b0;
    end

    // R5
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tag));
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
    parameter int NT = 4,
    parameter int CW = 16,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_view,
    input  logic          req_write,
    input  logic [TW-1:0] req_tid,
    input  logic [CW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [TW-1:0] rsp_tid,
    output logic [CW-1:0] rsp_data,
    output logic [CW-1:0] cell_count,
    output logic [NT-1:0] wait_mask
);
    import sem_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    view_e         view;
    cell_st_e      state_q, state_n;
    logic [CW-1:0] count_q, count_n;
    logic          is_load, is_store, tag_wr, tag_rd, park, wake;
    logic          any_wait, last_wait;
    logic [TW-1:0] head_tid;
    logic [CW-1:0] tag_word;
    logic          rsp_v_n;
    logic [TW-1:0] rsp_tid_n;
    logic [CW-1:0] rsp_data_n;
    logic          unused_wdata;

    assign view         = view_e'(req_view);
    assign unused_wdata = ^req_wdata[CW-1:2];

    always_comb begin
        is_load  = req_valid && !req_write && (view == VIEW_PV_BLOCK || view == VIEW_PV_TRY);
        is_store = req_valid &&  req_write && (view == VIEW_PV_BLOCK || view == VIEW_PV_TRY);
        tag_wr   = req_valid &&  req_write && (view == VIEW_TAG);
        tag_rd   = req_valid && !req_write && (view == VIEW_TAG);
        park     = is_load && (view == VIEW_PV_BLOCK) && (count_q == '0);
        wake     = is_store && any_wait;
    end

    sem_waitq #(.NT(NT)) u_waitq (
        .clk(clk), .rst_n(rst_n),
        .park_en(park), .park_tid(req_tid), .release_en(wake),
        .mask(wait_mask), .any(any_wait), .last(last_wait), .head_tid(head_tid)
    );

    sem_tag #(.CW(CW)) u_tag (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tag_wr), .wr_bits(req_wdata[1:0]), .tag(tag_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DRAINED;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_DRAINED: if (park) state_n = ST_BLOCKED;
                        else if (is_store) state_n = ST_HOLDING;
            ST_HOLDING: if (is_load && count_q == CW'(1)) state_n = ST_DRAINED;
            ST_BLOCKED: if (wake && last_wait) state_n = ST_DRAINED;
            default:    state_n = ST_DRAINED;
        endcase
    end

    // outputs and count
    always_comb begin
        rsp_v_n    = 1'b0;
        rsp_tid_n  = req_tid;
        rsp_data_n = '0;
        count_n    = count_q;
        if (tag_rd) begin
            rsp_v_n    = 1'b1;
            rsp_data_n = tag_word;
        end else if (is_load) begin
            if (count_q != '0) begin
                rsp_v_n    = 1'b1;
                rsp_data_n = count_q;
                count_n    = count_q - CW'(1);
            end else if (view == VIEW_PV_TRY) begin
                rsp_v_n = 1'b1;
            end
        end else if (is_store) begin
            if (any_wait) begin
                rsp_v_n    = 1'b1;
                rsp_tid_n  = head_tid;
                rsp_data_n = count_q + CW'(1);
            end else if (count_q != CNT_MAX) begin
                count_n = count_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_tid   <= '0;
            rsp_data  <= '0;
        end else begin
            count_q   <= count_n;
            rsp_valid <= rsp_v_n;
            rsp_tid   <= rsp_tid_n;
            rsp_data  <= rsp_data_n;
        end
    end

    assign cell_count = count_q;

    // R1
    holding_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDING) == (count_q != '0));

    // R3
    blocked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED) == (wait_mask != '0));

    // R1
    p_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && count_q != '0) |=> (count_q == $past(count_q) - CW'(1)));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    // R4
    try_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && view == VIEW_PV_TRY && count_q == '0)
            |=> (rsp_valid && rsp_data == '0 && $stable(wait_mask)));
endmodule

// File: tb/test_sem_cell.sv
module test_sem_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_view = 2'd0;
    logic        req_write = 1'b0;
    logic [1:0]  req_tid = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        rsp_valid;
    logic [1:0]  rsp_tid;
    logic [15:0] rsp_data;
    logic [15:0] cell_count;
    logic [3:0]  wait_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sem_cell i_sem_cell (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data),
        .cell_count(cell_count), .wait_mask(wait_mask)
    );

    // view, wr, tid, wdata | exp valid, exp tid, exp data, exp count, exp mask
    localparam int NV = 16;
    localparam logic [59:0] VEC [NV] = '{
        {2'd1,1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0000, 16'd0, 4'b0000}, // R4 try at zero
        {2'd0,1'b1,2'd1,16'h1234, 1'b0,2'd0,16'h0000, 16'd1, 4'b0000}, // R7 data ignored
        {2'd1,1'b1,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 16'd2, 4'b0000}, // R2
        {2'd0,1'b0,2'd3,16'h0000, 1'b1,2'd3,16'h0002, 16'd1, 4'b0000}, // R1
        {2'd1,1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0001, 16'd0, 4'b0000}, // R1
        {2'd0,1'b0,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 16'd0, 4'b0100}, // R3
        {2'd0,1'b0,2'd1,16'h0000, 1'b0,2'd0,16'h0000, 16'd0, 4'b0110}, // R3
        {2'd1,1'b1,2'd0,16'hFFFF, 1'b1,2'd1,16'h0001, 16'd0, 4'b0100}, // R8 lowest
        {2'd0,1'b1,2'd3,16'h0000, 1'b1,2'd2,16'h0001, 16'd0, 4'b0000}, // R8
        {2'd2,1'b1,2'd0,16'hFFF7, 1'b0,2'd0,16'h0000, 16'd0, 4'b0000}, // R6 write
        {2'd2,1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0003, 16'd0, 4'b0000}, // R6 read
        {2'd0,1'b1,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 16'd1, 4'b0000}, // R5
        {2'd0,1'b0,2'd0,16'h0000, 1'b1,2'd0,16'h0001, 16'd0, 4'b0000}, // R5
        {2'd2,1'b0,2'd1,16'h0000, 1'b1,2'd1,16'h0003, 16'd0, 4'b0000}, // R5 tag kept
        {2'd3,1'b1,2'd0,16'h0000, 1'b0,2'd0,16'h0000, 16'd0, 4'b0000}, // R10
        {2'd3,1'b0,2'd2,16'h0000, 1'b0,2'd0,16'h0000, 16'd0, 4'b0000}  // R10
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] v, input logic w, input logic [1:0] t, input logic [15:0] d);
        req_valid = 1'b1; req_view = v; req_write = w; req_tid = t; req_wdata = d;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(750000.0);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 rsp_valid at reset", 16'(rsp_valid), 16'h0);
        chk("R9 count at reset", cell_count, 16'h0);
        chk("R9 mask at reset", 16'(wait_mask), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][59:58], VEC[k][57], VEC[k][56:55], VEC[k][54:39]);
            @(negedge clk);
            chk($sformatf("vec %0d rsp_valid (R1-family)", k), 16'(rsp_valid), 16'(VEC[k][38]));
            if (VEC[k][38]) begin
                chk($sformatf("vec %0d rsp_tid", k), 16'(rsp_tid), 16'(VEC[k][37:36]));
                chk($sformatf("vec %0d rsp_data", k), rsp_data, VEC[k][35:20]);
            end
            chk($sformatf("vec %0d count", k), cell_count, VEC[k][19:4]);
            chk($sformatf("vec %0d wait_mask", k), 16'(wait_mask), 16'(VEC[k][3:0]));
        end
        req_valid = 1'b0;
        @(negedge clk);

        // R2 saturation: 65536 releases from zero
        drive(2'd1, 1'b1, 2'd0, 16'h0);
        for (int n = 0; n < 65536; n++) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 saturate at FFFF", cell_count, 16'hFFFF);
        drive(2'd0, 1'b0, 2'd1, 16'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 load at ceiling data", rsp_data, 16'hFFFF);
        chk("R1 load at ceiling count", cell_count, 16'hFFFE);

        // R9 reset with a parked thread and tag set
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd2, 1'b1, 2'd0, 16'h0003);
        @(negedge clk);
        drive(2'd0, 1'b0, 2'd2, 16'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 parked after reset", 16'(wait_mask), 16'h0004);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mask cleared", 16'(wait_mask), 16'h0);
        chk("R9 count cleared", cell_count, 16'h0);
        rst_n = 1'b1;
        drive(2'd2, 1'b0, 2'd0, 16'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 tag cleared", rsp_data, 16'h0000);

        done = 1'b1;
        finish_run();
    end
endmodule